// File: doc/BRIEF.md
# Status register field-masked write unit

This block holds the processor's current status word and the saved status word that belongs to the current mode. It carries out the two status-move operations. A write merges a 32-bit source value into one of the two words under the control of four byte-lane enables. A read returns either word. A restore operation copies the saved word back into the current word, which is the usual last step of an exception return. The low five bits of the current word hold the processor mode. The top four bits hold the N, Z, C and V condition flags. Mode 5'b10000 is the only unprivileged (user) mode.

Whenever an update would change the mode field, the unit raises a mode-change pulse in the same cycle as the request. The pulse carries the outgoing and incoming mode codes, so that neighbouring logic can swap register banks before the new word takes effect on the next clock edge. In user mode there is no saved word. Any attempt to touch it raises an error and changes nothing. A user-mode write to the current word can only alter the flags. Register banking and the generation of the source operand are left to the surrounding logic.

Top module: `psr_fieldwrite_unit`

## Requirements
- R1: While reset is active, and after it is released, the current word is 32'h0000_00D3 (supervisor mode 5'b10011, both interrupt-mask bits 7 and 6 set) and the saved word is zero. `cur_mode` reads 5'b10011.
- R2: In a privileged mode, a write to the current word with `wr_fields[k]` set replaces bits 8k+7:8k with the matching bits of `wr_value`. Lanes whose enable is clear keep their old contents, and with all four enables clear nothing changes.
- R3: In user mode, a write to the current word loads bits 31:28 from `wr_value` and keeps bits 27:0, whatever the field enables are.
- R4: In user mode, a write aimed at the saved word, a restore request, or a read with `rd_saved_sel` high drives `access_err` high in that same cycle. Neither the saved word nor, for a restore, the current word changes.
- R5: In a privileged mode, a write aimed at the saved word loads all 32 bits of `wr_value`, ignores the field enables and leaves the current word unchanged.
- R6: `rd_data` shows the saved word when `rd_saved_sel` is 1 and the current word when it is 0, without a clock edge.
- R7: When an accepted update would change bits 4:0 of the current word, `mode_chg_pulse` is high in the request cycle, with `mode_prev` equal to the present mode and `mode_next` equal to the new one. `cur_mode` shows the new mode after the next rising edge. An update that keeps the mode gives no pulse.
- R8: In a privileged mode, a restore copies the saved word into the current word at the next edge and gives a mode-change pulse only if the two mode fields differ.
- R9: When a restore and a write are requested in the same cycle, the restore is carried out and the write is dropped.
- R10: With neither `wr_en` nor `restore_en` high, both words hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_value | input | 32 | Source value for a write |
| wr_fields | input | 4 | Byte-lane enables, bit k covers bits 8k+7:8k |
| wr_to_saved | input | 1 | 1 = the write targets the saved word |
| restore_en | input | 1 | Copy the saved word into the current word |
| rd_saved_sel | input | 1 | 1 = read the saved word, 0 = read the current word |
| rd_data | output | 32 | Selected status word |
| cur_mode | output | 5 | Mode field of the current word |
| mode_chg_pulse | output | 1 | High in a request cycle whose update changes the mode |
| mode_prev | output | 5 | Mode before the pending update |
| mode_next | output | 5 | Mode after the pending update |
| access_err | output | 1 | Saved-word access attempted in user mode |

## Verification
A wrong lane merge shows up on `rd_data` one edge after the write, and only in the lanes that are affected. The bench therefore reads the current word back after each write and compares all 32 bits. A mode field that is held wrongly shows at once on `cur_mode`. It also corrupts every later decision: whether a user-mode write is limited to the flags, whether `access_err` fires, and what a later restore should pulse. Errors and mode pulses are combinational, so they are checked inside the request cycle itself, before the edge that applies the update.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int PSR_W    = 32;
  localparam int MODE_W   = 5;
  localparam int LANES    = 4;
  localparam int LANE_W   = PSR_W / LANES;
  localparam int FLAG_W   = 4;
  localparam int FLAG_LSB = PSR_W - FLAG_W;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [PSR_W-1:0]  psr_t;

  localparam mode_t MODE_USR = 5'b10000;
  localparam mode_t MODE_SVC = 5'b10011;
  localparam psr_t  PSR_RST  = {{(PSR_W-8){1'b0}}, 3'b110, MODE_SVC};

  typedef struct packed {
    logic  fire;
    mode_t prev;
    mode_t next;
  } mode_evt_t;

  // keep old bits where mask is clear, take new bits where it is set
  function automatic psr_t lane_merge(input psr_t old_w, input psr_t new_w, input psr_t mask);
    return (old_w & ~mask) | (new_w & mask);
  endfunction

  // user-mode write: condition flags only
  function automatic psr_t flags_only(input psr_t old_w, input psr_t new_w);
    psr_t fmask;
    fmask = {{FLAG_W{1'b1}}, {FLAG_LSB{1'b0}}};
    return lane_merge(old_w, new_w, fmask);
  endfunction

  function automatic mode_t mode_of(input psr_t w);
    return w[MODE_W-1:0];
  endfunction

endpackage

// File: rtl/psr_lane_mask.sv
module psr_lane_mask #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0]        lane_en,
  output logic [LANES*LANE_W-1:0] mask
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[g*LANE_W +: LANE_W] = {LANE_W{lane_en[g]}};
  end
endmodule

// File: rtl/psr_update_ctl.sv
module psr_update_ctl
  import psr_pkg::*;
(
  input  psr_t      cpsr_q,
  input  psr_t      spsr_q,
  input  logic      wr_en,
  input  psr_t      wr_value,
  input  psr_t      wr_mask,
  input  logic      wr_to_saved,
  input  logic      restore_en,
  input  logic      rd_saved_sel,
  output psr_t      cpsr_d,
  output logic      cpsr_load,
  output logic      spsr_load,
  output mode_evt_t evt,
  output logic      err
);
  logic is_user;
  logic restore_ok;
  logic cpsr_wr;

  assign is_user    = (mode_of(cpsr_q) == MODE_USR);
  assign restore_ok = restore_en && !is_user;
  assign cpsr_wr    = wr_en && !wr_to_saved && !restore_en;
  assign spsr_load  = wr_en && wr_to_saved && !restore_en && !is_user;
  assign cpsr_load  = restore_ok || cpsr_wr;

  always_comb begin
    if (restore_ok)   cpsr_d = spsr_q;
    else if (is_user) cpsr_d = flags_only(cpsr_q, wr_value);
    else              cpsr_d = lane_merge(cpsr_q, wr_value, wr_mask);
  end

  assign evt.prev = mode_of(cpsr_q);
  assign evt.next = cpsr_load ? mode_of(cpsr_d) : mode_of(cpsr_q);
  assign evt.fire = cpsr_load && (mode_of(cpsr_d) != mode_of(cpsr_q));

  assign err = is_user && (restore_en || (wr_en && wr_to_saved) || rd_saved_sel);
endmodule

// File: rtl/psr_fieldwrite_unit.sv
module psr_fieldwrite_unit
  import psr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PSR_W-1:0]      wr_value,
  input  logic [LANES-1:0]      wr_fields,
  input  logic                  wr_to_saved,
  input  logic                  restore_en,
  input  logic                  rd_saved_sel,
  output logic [PSR_W-1:0]      rd_data,
  output logic [MODE_W-1:0]     cur_mode,
  output logic                  mode_chg_pulse,
  output logic [MODE_W-1:0]     mode_prev,
  output logic [MODE_W-1:0]     mode_next,
  output logic                  access_err
);
  psr_t      cpsr_q, spsr_q, cpsr_d, wr_mask;
  logic      cpsr_load, spsr_load;
  mode_evt_t evt;

  psr_lane_mask #(.LANES(LANES), .LANE_W(LANE_W)) u_mask (
    .lane_en (wr_fields),
    .mask    (wr_mask)
  );

  psr_update_ctl u_ctl (
    .cpsr_q       (cpsr_q),
    .spsr_q       (spsr_q),
    .wr_en        (wr_en),
    .wr_value     (wr_value),
    .wr_mask      (wr_mask),
    .wr_to_saved  (wr_to_saved),
    .restore_en   (restore_en),
    .rd_saved_sel (rd_saved_sel),
    .cpsr_d       (cpsr_d),
    .cpsr_load    (cpsr_load),
    .spsr_load    (spsr_load),
    .evt          (evt),
    .err          (access_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpsr_q <= PSR_RST;
      spsr_q <= '0;
    end else begin
      if (cpsr_load) cpsr_q <= cpsr_d;
      if (spsr_load) spsr_q <= wr_value;
    end
  end

  assign rd_data        = rd_saved_sel ? spsr_q : cpsr_q;
  assign cur_mode       = mode_of(cpsr_q);
  assign mode_chg_pulse = evt.fire;
  assign mode_prev      = evt.prev;
  assign mode_next      = evt.next;
endmodule

// File: rtl/psr_fieldwrite_chk.sv
module psr_fieldwrite_chk
  import psr_pkg::*;
(
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         wr_to_saved,
  input logic         restore_en,
  input logic [4:0]   cur_mode,
  input logic         mode_chg_pulse,
  input logic [4:0]   mode_prev,
  input logic [4:0]   mode_next,
  input logic         access_err,
  input logic [31:0]  cpsr_q,
  input logic [31:0]  spsr_q
);
  // R7
  pulse_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_pulse |=> cur_mode == $past(mode_next));

  // R7
  pulse_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_pulse |-> (mode_prev != mode_next) && (mode_prev == cur_mode));

  // R4
  err_saved_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |=> $stable(spsr_q));

  // R3
  user_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_USR && wr_en && !wr_to_saved && !restore_en)
      |=> cpsr_q[27:0] == $past(cpsr_q[27:0]));

  // R8
  restore_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_en && cur_mode != MODE_USR) |=> cpsr_q == $past(spsr_q));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !restore_en) |=> $stable(cpsr_q) && $stable(spsr_q));
endmodule

bind psr_fieldwrite_unit psr_fieldwrite_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en          (wr_en),
  .wr_to_saved    (wr_to_saved),
  .restore_en     (restore_en),
  .cur_mode       (cur_mode),
  .mode_chg_pulse (mode_chg_pulse),
  .mode_prev      (mode_prev),
  .mode_next      (mode_next),
  .access_err     (access_err),
  .cpsr_q         (cpsr_q),
  .spsr_q         (spsr_q)
);

// File: tb/psr_fieldwrite_unit_bench.sv
module psr_fieldwrite_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_to_saved, restore_en, rd_saved_sel;
  logic [31:0] wr_value;
  logic [3:0]  wr_fields;
  logic [31:0] rd_data;
  logic [4:0]  cur_mode, mode_prev, mode_next;
  logic        mode_chg_pulse, access_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_cur, m_sav;

  typedef struct {
    string       tag;
    logic [31:0] exp_rd;
    logic [4:0]  exp_mode;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  psr_fieldwrite_unit u_psr_fieldwrite_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_value(wr_value),
    .wr_fields(wr_fields), .wr_to_saved(wr_to_saved), .restore_en(restore_en),
    .rd_saved_sel(rd_saved_sel), .rd_data(rd_data), .cur_mode(cur_mode),
    .mode_chg_pulse(mode_chg_pulse), .mode_prev(mode_prev),
    .mode_next(mode_next), .access_err(access_err)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops one expected item per read, after the edge that follows it
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check({it.tag, " rd_data"}, rd_data, it.exp_rd);
      check({it.tag, " cur_mode"}, {27'd0, cur_mode}, {27'd0, it.exp_mode});
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; wr_value = 0; wr_fields = 0;
    wr_to_saved = 0; restore_en = 0; rd_saved_sel = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_cur = 32'h0000_00D3;
    m_sav = 32'h0;
  endtask

  task automatic do_read(input string tag, input logic sel);
    item_t it;
    @(negedge clk);
    rd_saved_sel = sel;
    it.tag = tag;
    it.exp_rd = sel ? m_sav : m_cur;
    it.exp_mode = m_cur[4:0];
    sb_q.push_back(it);
    #1;
    check({tag, " read err"}, {31'd0, access_err},
          {31'd0, sel && (m_cur[4:0] == 5'b10000)});
    @(negedge clk);
    rd_saved_sel = 0;
  endtask

  task automatic do_op(input string tag, input logic we, input logic [31:0] val,
                       input logic [3:0] fld, input logic sav, input logic rs);
    logic        user, e_err, e_pulse;
    logic [31:0] n_cur, n_sav;
    user  = (m_cur[4:0] == 5'b10000);
    n_cur = m_cur;
    n_sav = m_sav;
    if (rs) begin
      if (!user) n_cur = m_sav;
    end else if (we) begin
      if (sav) begin
        if (!user) n_sav = val;
      end else if (user) begin
        n_cur = {val[31:28], m_cur[27:0]};
      end else begin
        for (int i = 0; i < 4; i++)
          if (fld[i]) n_cur[i*8 +: 8] = val[i*8 +: 8];
      end
    end
    e_err   = user && (rs || (we && sav));
    e_pulse = (n_cur[4:0] != m_cur[4:0]);
    @(negedge clk);
    wr_en = we; wr_value = val; wr_fields = fld; wr_to_saved = sav; restore_en = rs;
    #1;
    check({tag, " pulse"}, {31'd0, mode_chg_pulse}, {31'd0, e_pulse});
    check({tag, " err"}, {31'd0, access_err}, {31'd0, e_err});
    if (e_pulse) begin
      check({tag, " mode_prev"}, {27'd0, mode_prev}, {27'd0, m_cur[4:0]});
      check({tag, " mode_next"}, {27'd0, mode_next}, {27'd0, n_cur[4:0]});
    end
    @(negedge clk);
    wr_en = 0; wr_to_saved = 0; restore_en = 0; wr_fields = 0;
    m_cur = n_cur;
    m_sav = n_sav;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset values
    do_read("R1 current", 1'b0);
    do_read("R1 saved", 1'b1);
    // R2 lane 0 write to system mode, R7 pulse
    do_op("R2 R7 low lane", 1, 32'h0000_001F, 4'b0001, 0, 0);
    do_read("R2 after low lane", 1'b0);
    // R2 top lane only, R7 no pulse
    do_op("R2 top lane", 1, 32'hF0FF_FFFF, 4'b1000, 0, 0);
    do_read("R2 after top lane", 1'b0);
    // R2 middle lanes
    do_op("R2 mid lanes", 1, 32'h00AB_CD00, 4'b0110, 0, 0);
    do_read("R2 after mid lanes", 1'b0);
    // R2 no lanes enabled
    do_op("R2 no lanes", 1, 32'hFFFF_FFFF, 4'b0000, 0, 0);
    do_read("R2 after no lanes", 1'b0);
    // R5 saved write ignores field enables
    do_op("R5 saved write", 1, 32'h1234_5610, 4'b0000, 1, 0);
    do_read("R5 saved value", 1'b1);
    do_read("R5 current kept", 1'b0);
    // R10 idle
    do_op("R10 idle", 0, 32'hDEAD_BEEF, 4'b1111, 0, 0);
    repeat (4) @(negedge clk);
    do_read("R10 current held", 1'b0);
    do_read("R10 saved held", 1'b1);
    // R8 R9 restore wins over write; mode 1F -> 10
    do_op("R8 R9 restore", 1, 32'hFFFF_FFFF, 4'b1111, 0, 1);
    do_read("R8 R9 after restore", 1'b0);
    // R3 user write only touches flags
    do_op("R3 user write", 1, 32'hA000_001F, 4'b1111, 0, 0);
    do_read("R3 after user write", 1'b0);
    // R4 user saved write, restore and read
    do_op("R4 user saved write", 1, 32'h5555_5555, 4'b1111, 1, 0);
    do_op("R4 user restore", 0, 32'h0, 4'b0000, 0, 1);
    do_read("R4 user saved read", 1'b1);
    do_read("R4 current unchanged", 1'b0);
    // R8 restore with equal modes: no pulse
    do_reset();
    do_op("R8 saved svc", 1, 32'h0000_0093, 4'b0000, 1, 0);
    do_op("R8 same-mode restore", 0, 32'h0, 4'b0000, 0, 1);
    do_read("R8 R6 after same-mode restore", 1'b0);
    // R7 privileged write into user mode
    do_op("R7 enter user", 1, 32'h0000_0010, 4'b0001, 0, 0);
    do_read("R7 user mode", 1'b0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule